// File: doc/BRIEF.md
# Periodic Recirculating Tap Delay Loop

This block delivers one slow input stream to M output taps. Each tap shows the sample that a long delay line would give if the delay-line pick point moved with the slot number. The input changes only once every P clock cycles. Those P cycles are the slots 0 to P−1 of a sample period, and a new value arrives at the start of slot 0. A long delay line with one P-to-1 selector per tap would need (P·M − 1)·P registers. This block instead keeps a short ring of P·M − 1 registers closed through a single 2-to-1 selector. Each sample circulates P times through the ring before it is overwritten.

The selector takes the new input in slot 0 and the ring's own last stage in every other slot. Tap j is read at a fixed ring position, so the taps need no selection logic at all. A modulo-P slot counter sets the selector. A slot-0 strobe pulls the counter into phase, and the counter keeps running on its own between strobes. The block is used where a folded, time-multiplexed datapath needs the time-varying taps of a long delay line at a fraction of its register count.

Top module: `rloop_top`

## Requirements
- R1: While reset is held, every register clears, so all tap outputs and the exit output read zero on the clock after reset is sampled low.
- R2: A high `slot0_i` marks the current cycle as slot 0. Without a strobe, the slot number advances by one per cycle and wraps from P−1 to 0, so a single strobe is enough to keep alignment.
- R3: In slot 0 the first ring register loads `din_i`. In every other slot it loads the value of the last ring register.
- R4: The ring holds exactly P·M − 1 registers. Tap j (j = 1..M, placed on bits [(j−1)·W +: W] of `tap_o`) is the output of ring register j·P − 1 counted from the selector. `exit_o` is the output of the last ring register.
- R5: In every cycle of slot i, tap j equals the input as it was ((P−1−i)·M + j − 1)·P cycles earlier. Before reset release the input counts as zero.
- R6: In slot 0, `exit_o` equals the input as it was (P·M − 1)·P cycles earlier.
- R7: `din_i` has no effect on any output in slots 1 to P−1. Only the value present in slot 0 enters the ring.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot0_i | input | 1 | Strobe marking the current cycle as slot 0 |
| din_i | input | W | Slow input sample, read in slot 0 |
| tap_o | output | M×W | M tap outputs, tap j on bits [(j−1)·W +: W] |
| exit_o | output | W | Ring exit value, valid as the delayed input in slot 0 |

## Verification
The bench builds the block with P = 3, M = 3 and an 8-bit data path. This gives an 8-register ring whose tap delays range from 0 to 24 cycles, and every slot, tap and wrap of the counter is reached within a few sample periods. A behavioural history of the input predicts every tap in every cycle and the exit in slot 0. The run has three phases: strobes every period, a single strobe with a free-running counter, and junk on the input outside slot 0. It then applies a mid-run reset.

// File: rtl/rloop_pkg.sv
package rloop_pkg;

  // Number of registers in the recirculating ring for period p and tap count m.
  function automatic int unsigned loop_len(input int unsigned p, input int unsigned m);
    return p * m - 1;
  endfunction

  // Ring position (registers after the selector) of tap j, j counted from 1.
  function automatic int unsigned tap_depth(input int unsigned p, input int unsigned j);
    return j * p - 1;
  endfunction

  // Delay, in clock cycles, that tap j shows in slot i of the equivalent long line.
  function automatic int unsigned line_delay(input int unsigned p, input int unsigned m,
                                             input int unsigned i, input int unsigned j);
    return ((p - 1 - i) * m + (j - 1)) * p;
  endfunction

endpackage

// File: rtl/rloop_slot_ctr.sv
module rloop_slot_ctr #(
  parameter int P = 4,
  localparam int SW = (P > 1) ? $clog2(P) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot0_strobe,
  output logic [SW-1:0] slot_idx,
  output logic          slot_zero
);

  localparam logic [SW-1:0] LAST = SW'(P - 1);

  logic [SW-1:0] cnt_q;

  // The strobe overrides the stored count for the current cycle.
  assign slot_idx  = slot0_strobe ? '0 : cnt_q;
  assign slot_zero = (slot_idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (slot_idx == LAST) cnt_q <= '0;
    else                       cnt_q <= slot_idx + SW'(1);
  end

  // R2
  strobe_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot0_strobe |=> (slot0_strobe || slot_idx == SW'(1)));

  // R2
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx == LAST) |=> (slot0_strobe || slot_idx == '0));

  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx != LAST) |=> (slot0_strobe || slot_idx == SW'($past(slot_idx) + SW'(1))));

endmodule

// File: rtl/rloop_ring.sv
module rloop_ring #(
  parameter int W   = 16,
  parameter int LEN = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   take_new,
  input  logic [W-1:0]           din,
  output logic [LEN:1][W-1:0]    stage_o
);

  logic [LEN:1][W-1:0] stage_q;
  logic [W-1:0]        feed;
  logic [W-1:0]        ring_tail;

  assign ring_tail = stage_q[LEN];
  // The single 2-to-1 selector of the loop.
  assign feed      = take_new ? din : ring_tail;

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[1] <= '0;
    else        stage_q[1] <= feed;
  end

  for (genvar k = 2; k <= LEN; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[k] <= '0;
      else        stage_q[k] <= stage_q[k-1];
    end

    // R4
    shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> stage_q[k] == $past(stage_q[k-1]));
  end

  assign stage_o = stage_q;

  // R3
  load_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_new |=> stage_q[1] == $past(din));

  // R3
  recirc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_new |=> stage_q[1] == $past(ring_tail));

endmodule

// File: rtl/rloop_top.sv
module rloop_top
  import rloop_pkg::*;
#(
  parameter int P = 4,
  parameter int M = 3,
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slot0_i,
  input  logic [W-1:0]         din_i,
  output logic [M-1:0][W-1:0]  tap_o,
  output logic [W-1:0]         exit_o
);

  localparam int LEN = int'(loop_len(P, M));
  localparam int SW  = (P > 1) ? $clog2(P) : 1;

  logic [SW-1:0]       slot_idx;
  logic                slot_zero;
  logic [LEN:1][W-1:0] ring;

  rloop_slot_ctr #(.P(P)) u_ctr (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot0_strobe (slot0_i),
    .slot_idx     (slot_idx),
    .slot_zero    (slot_zero)
  );

  rloop_ring #(.W(W), .LEN(LEN)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_new (slot_zero),
    .din      (din_i),
    .stage_o  (ring)
  );

  // Taps sit at fixed ring positions: no selection logic per tap.
  for (genvar j = 1; j <= M; j++) begin : g_tap
    localparam int POS = int'(tap_depth(P, j));
    assign tap_o[j-1] = ring[POS];
  end

  assign exit_o = ring[LEN];

  // R7: a value held across a slot-0 boundary at the first stage recirculates
  // unchanged whatever din_i does outside slot 0.
  ignore_din_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_zero |=> ring[1] == $past(exit_o));

  // R6: the value leaving the ring in slot 0 is pushed out by the new sample.
  exit_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_zero |=> ring[1] == $past(din_i));

endmodule

// File: tb/rloop_top_tb.sv
`timescale 1ns/1ps
module rloop_top_tb;
  localparam int P    = 3;
  localparam int M    = 3;
  localparam int W    = 8;
  localparam int NCYC = 900;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                rst_n;
  logic                slot0;
  logic [W-1:0]        din;
  logic [M-1:0][W-1:0] tap;
  logic [W-1:0]        ex;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 1'b0;

  logic [W-1:0] hist [0:NCYC-1];
  logic [W-1:0] blk;

  rloop_top #(.P(P), .M(M), .W(W)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot0_i (slot0),
    .din_i   (din),
    .tap_o   (tap),
    .exit_o  (ex)
  );

  function automatic logic [W-1:0] past_x(input int idx);
    if (idx < 0) return '0;
    return hist[idx];
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    slot0 = 1'b0;
    din   = '0;
    blk   = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs cleared while in reset
    check("R1 exit in reset", ex, '0);
    for (int j = 0; j < M; j++) check($sformatf("R1 tap%0d in reset", j + 1), tap[j], '0);
    rst_n = 1'b1;

    for (int n = 0; n < NCYC; n++) begin
      int slot;
      int phase;
      string tg;
      if (n > 0) @(negedge clk);
      slot  = n % P;
      phase = (n < 300) ? 0 : ((n < 600) ? 1 : 2);
      if (slot == 0) begin
        if ((n / P) % 17 == 5)      blk = '1;
        else if ((n / P) % 17 == 6) blk = '0;
        else                        blk = W'($urandom);
      end
      // phase 1: only the first cycle of the phase carries a strobe (R2)
      slot0 = (slot == 0) && (phase != 1 || n == 300);
      // phase 2: junk on the input outside slot 0 (R7)
      din   = (phase == 2 && slot != 0) ? W'($urandom) : blk;
      hist[n] = blk;
      #1;
      tg = (phase == 0) ? "R4 R5" : ((phase == 1) ? "R2 R5" : "R7 R5");
      for (int j = 0; j < M; j++) begin
        int t;
        t = ((P - 1 - slot) * M + j) * P;
        check($sformatf("%s tap%0d cycle %0d", tg, j + 1, n), tap[j], past_x(n - t));
      end
      if (slot == 0)
        check($sformatf("R3 R6 exit cycle %0d", n), ex, past_x(n - (P * M - 1) * P));
    end

    // R1: reset in the middle of a run clears the ring
    @(negedge clk);
    rst_n = 1'b0;
    slot0 = 1'b0;
    @(posedge clk);
    @(negedge clk);
    #1;
    check("R1 exit after mid-run reset", ex, '0);
    for (int j = 0; j < M; j++) check($sformatf("R1 tap%0d after mid-run reset", j + 1), tap[j], '0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule